// File: doc/BRIEF.md
# Sample Count Interrupt Controller

This block counts completed sample transfers for an audio engine and raises an interrupt once a programmed number of samples has moved. It has three down-counters: playback, capture and a general timer. Each counter has a 16-bit base value that software writes as two bytes, and it reloads from that base whenever it passes zero. Each counter that passes zero sets its own flag. The global interrupt status is the OR of the flags. The interrupt line is that status gated by an enable bit and registered.

Software uses a small byte-wide register bus. A write takes effect at the clock edge. Reads are combinational from the address. A single-channel mode input makes capture transfers share the playback counter and flag, so only one direction can run at a time. With the mode input low, both directions count independently.

The transfer and tick inputs are plain one-cycle pulses with no back-pressure: every pulse seen at an edge is counted. The block has no data stream, so it has no valid/ready interface.

Top module: `dma_count_irq`

## Requirements
- R1: Each play_xfer pulse decrements the playback count. A pulse that arrives while the count is zero sets flag bit 0 and reloads the count from the playback base instead of decrementing. The flag therefore sets on every (base+1)-th transfer.
- R2: With mode_single low, cap_xfer works on the capture counter in the same way and sets flag bit 1.
- R3: timer_tick works on the timer counter in the same way and sets flag bit 2.
- R4: Reading address 7 returns the global status in bit 0. It is 1 exactly when any flag bit is set, whatever the enable bit is.
- R5: A write of any value to address 7 clears all three flag bits, and with them the status.
- R6: A write to address 6 clears every flag bit whose data bit is 0 and leaves every flag bit whose data bit is 1 unchanged. A read of address 6 returns the flags in bits 2:0.
- R7: If a flag-clearing write and a new zero-crossing on the same source occur in the same cycle, that flag ends up set.
- R8: irq is a register that takes (status AND enable) at each edge. The enable is bit 0 of address 8. While the enable is 0, irq stays low and the status still follows counter events.
- R9: With mode_single high, cap_xfer decrements the playback counter and sets flag bit 1's neighbour, flag bit 0. A pulse on play_xfer or cap_xfer or both in one cycle counts once. The capture counter is untouched and flag bit 1 never sets from counting.
- R10: Addresses 0/1, 2/3 and 4/5 hold the low/high bytes of the playback, capture and timer bases, and reads return them. A write to either byte also loads the counter with the new 16-bit base, and this load takes priority over a same-cycle decrement.
- R11: After reset, all bases, counts, flags and the enable are zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| mode_single | input | 1 | 1: capture shares the playback counter |
| play_xfer | input | 1 | Completed playback sample pulse |
| cap_xfer | input | 1 | Completed capture sample pulse |
| timer_tick | input | 1 | Timer count pulse |
| irq | output | 1 | Masked, registered interrupt request |

## Verification
A wrong count or a missed reload does not show at once. It appears as a flag that sets one or more transfers early or late, so the bench compares the flag register after every single cycle against a cycle-exact model. A wrong flag update shows in the status read on the same cycle and on irq one edge later. Because of this, the masking and the same-cycle clear/set race are checked at exactly those edges.

// File: rtl/dcic_pkg.sv
package dcic_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int NSRC   = 3;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam int SRC_PLAY = 0;
  localparam int SRC_CAP  = 1;
  localparam int SRC_TMR  = 2;

  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(2 * NSRC);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(2 * NSRC + 1);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(2 * NSRC + 2);
endpackage

// File: rtl/dcic_counter.sv
module dcic_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  dec,
  output logic [2*BYTE_W-1:0]   base_o,
  output logic                  evt_o
);
  localparam int CW = 2 * BYTE_W;

  logic [CW-1:0] base_q, base_d, count_q;
  logic          ld;

  assign ld = wr_lo | wr_hi;

  always_comb begin
    base_d = base_q;
    if (wr_lo) base_d[BYTE_W-1:0]  = wdata;
    if (wr_hi) base_d[CW-1:BYTE_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      count_q <= '0;
    end else begin
      base_q <= base_d;
      if (ld)
        count_q <= base_d;
      else if (dec)
        count_q <= (count_q == '0) ? base_q : count_q - 1'b1;
    end
  end

  assign evt_o  = dec && (count_q == '0);
  assign base_o = base_q;

  // R1
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && count_q == '0 && !ld) |=> count_q == $past(base_q));

  // R1
  decr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && count_q != '0 && !ld) |=> count_q == $past(count_q) - 1'b1);

  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> count_q[BYTE_W-1:0] == $past(wdata));
endmodule

// File: rtl/dcic_flags.sv
module dcic_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  input  logic            ien,
  output logic [NSRC-1:0] flags,
  output logic            int_o,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | evt;
      irq   <= int_o & ien;
    end
  end

  assign int_o = |flags;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));

  // R8
  ien_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |=> !irq);

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&clr) && evt == '0) |=> flags == '0);
endmodule

// File: rtl/dma_count_irq.sv
module dma_count_irq
  import dcic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              mode_single,
  input  logic              play_xfer,
  input  logic              cap_xfer,
  input  logic              timer_tick,
  output logic              irq
);
  logic [NSRC-1:0]  dec, evt, clr, flags;
  logic [CNT_W-1:0] base [NSRC];
  logic             ien_q, int_w;

  always_comb begin
    dec           = '0;
    dec[SRC_PLAY] = mode_single ? (play_xfer | cap_xfer) : play_xfer;
    dec[SRC_CAP]  = mode_single ? 1'b0 : cap_xfer;
    dec[SRC_TMR]  = timer_tick;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_cnt
    dcic_counter #(.BYTE_W(BYTE_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (reg_wr && reg_addr == ADDR_W'(2 * i)),
      .wr_hi  (reg_wr && reg_addr == ADDR_W'(2 * i + 1)),
      .wdata  (reg_wdata),
      .dec    (dec[i]),
      .base_o (base[i]),
      .evt_o  (evt[i])
    );
  end

  always_comb begin
    clr = '0;
    if (reg_wr && reg_addr == A_FLAGS)  clr = ~reg_wdata[NSRC-1:0];
    if (reg_wr && reg_addr == A_STATUS) clr = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ien_q <= 1'b0;
    else if (reg_wr && reg_addr == A_CTRL)  ien_q <= reg_wdata[0];
  end

  dcic_flags #(.NSRC(NSRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .clr   (clr),
    .ien   (ien_q),
    .flags (flags),
    .int_o (int_w),
    .irq   (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_addr == ADDR_W'(2 * i))     reg_rdata = base[i][BYTE_W-1:0];
      if (reg_addr == ADDR_W'(2 * i + 1)) reg_rdata = base[i][CNT_W-1:BYTE_W];
    end
    if (reg_addr == A_FLAGS)  reg_rdata = BYTE_W'(flags);
    if (reg_addr == A_STATUS) reg_rdata = BYTE_W'(int_w);
    if (reg_addr == A_CTRL)   reg_rdata = BYTE_W'(ien_q);
  end

  // R9
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_single && cap_xfer) |=> !$rose(flags[SRC_CAP]));
endmodule

// File: tb/sim_dma_count_irq.sv
module sim_dma_count_irq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, reg_wr, mode_single, play_xfer, cap_xfer, timer_tick;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  wire  [7:0] reg_rdata;
  wire        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] m_base [3];
  logic [15:0] m_cnt  [3];
  logic [2:0]  m_flags;
  logic        m_ien, m_irq;

  dma_count_irq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_single(mode_single),
    .play_xfer(play_xfer), .cap_xfer(cap_xfer), .timer_tick(timer_tick),
    .irq(irq)
  );

  function automatic logic [15:0] next_base(input int i, input logic wr,
      input logic [3:0] a, input logic [7:0] d);
    logic [15:0] b = m_base[i];
    if (wr && a == 4'(2*i))   b[7:0]  = d;
    if (wr && a == 4'(2*i+1)) b[15:8] = d;
    return b;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic wr, input logic [3:0] a, input logic [7:0] d,
                      input logic p, input logic c, input logic t);
    logic [2:0] dec, evt, clr, nf;
    logic [15:0] nb [3];
    logic [15:0] nc [3];
    logic nirq, nien;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    play_xfer = p; cap_xfer = c; timer_tick = t;
    dec = {t, mode_single ? 1'b0 : c, mode_single ? (p | c) : p};
    for (int i = 0; i < 3; i++) begin
      evt[i] = dec[i] && m_cnt[i] == 16'd0;
      nb[i] = next_base(i, wr, a, d);
      if (wr && (a == 4'(2*i) || a == 4'(2*i+1))) nc[i] = nb[i];
      else if (dec[i]) nc[i] = (m_cnt[i] == 16'd0) ? m_base[i] : m_cnt[i] - 16'd1;
      else nc[i] = m_cnt[i];
    end
    clr = 3'b000;
    if (wr && a == 4'd6) clr = ~d[2:0];
    if (wr && a == 4'd7) clr = 3'b111;
    nf = (m_flags & ~clr) | evt;
    nirq = (|m_flags) & m_ien;
    nien = (wr && a == 4'd8) ? d[0] : m_ien;
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      m_base[i] = nb[i];
      m_cnt[i] = nc[i];
    end
    m_flags = nf; m_irq = nirq; m_ien = nien;
    @(negedge clk);
    reg_wr = 0; play_xfer = 0; cap_xfer = 0; timer_tick = 0;
  endtask

  task automatic check_all(input string tag);
    reg_addr = 4'd6; #1;
    chk({tag, " flags"}, 16'(reg_rdata), 16'(m_flags));
    reg_addr = 4'd7; #1;
    chk({tag, " status"}, 16'(reg_rdata), 16'(|m_flags));
    chk({tag, " irq"}, 16'(irq), 16'(m_irq));
  endtask

  task automatic check_bases(input string tag);
    for (int i = 0; i < 6; i++) begin
      reg_addr = 4'(i); #1;
      chk(tag, 16'(reg_rdata), (i % 2 == 0) ? 16'(m_base[i/2][7:0]) : 16'(m_base[i/2][15:8]));
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; mode_single = 0;
    play_xfer = 0; cap_xfer = 0; timer_tick = 0;
    for (int i = 0; i < 3; i++) begin m_base[i] = 0; m_cnt[i] = 0; end
    m_flags = 0; m_ien = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R11 reset state
    check_all("R11");
    check_bases("R11 base");
    reg_addr = 4'd8; #1; chk("R11 ien", 16'(reg_rdata), 16'd0);

    // R10 base write and readback; R1 period base+1
    tick(1, 4'd0, 8'd2, 0, 0, 0);
    tick(1, 4'd1, 8'd0, 0, 0, 0);
    check_bases("R10 readback");
    tick(0, 4'd0, 8'd0, 1, 0, 0); check_all("R1 first");
    tick(0, 4'd0, 8'd0, 1, 0, 0); check_all("R1 second");
    tick(0, 4'd0, 8'd0, 1, 0, 0); check_all("R1 third sets");
    chk("R1 flag bit0", 16'(m_flags), 16'd1);

    // R8 masked: status set, irq low
    tick(0, 4'd0, 8'd0, 0, 0, 0); check_all("R8 masked");
    chk("R8 irq low", 16'(irq), 16'd0);
    tick(1, 4'd8, 8'd1, 0, 0, 0); check_all("R8 enable edge");
    tick(0, 4'd0, 8'd0, 0, 0, 0); check_all("R8 enabled");
    chk("R8 irq high", 16'(irq), 16'd1);

    // R2 capture, R6 selective clear
    tick(1, 4'd2, 8'd0, 0, 0, 0);
    tick(0, 4'd0, 8'd0, 0, 1, 0); check_all("R2 cap flag");
    tick(1, 4'd6, 8'hFE, 0, 0, 0); check_all("R6 clear bit0");
    chk("R6 flags", 16'(m_flags), 16'd2);

    // R3 timer, R5 status write clears all
    tick(0, 4'd0, 8'd0, 0, 0, 1); check_all("R3 timer");
    tick(1, 4'd7, 8'h5A, 0, 0, 0); check_all("R5 clear all");
    chk("R5 flags zero", 16'(m_flags), 16'd0);
    tick(0, 4'd0, 8'd0, 0, 0, 0); check_all("R4 status idle");

    // R7 clear and set same cycle
    tick(1, 4'd0, 8'd0, 0, 0, 0);
    tick(1, 4'd6, 8'h00, 1, 0, 0); check_all("R7 set wins");
    chk("R7 flag", 16'(m_flags), 16'd1);

    // R9 single mode
    tick(1, 4'd7, 8'd0, 0, 0, 0);
    mode_single = 1;
    tick(1, 4'd0, 8'd1, 0, 0, 0);
    tick(0, 4'd0, 8'd0, 0, 1, 0); check_all("R9 cap first");
    tick(0, 4'd0, 8'd0, 1, 1, 0); check_all("R9 both once");
    chk("R9 play flag only", 16'(m_flags), 16'd1);
    mode_single = 0;

    // Random run mixed with all of the above
    for (int n = 0; n < 3000; n++) begin
      logic wr;
      logic [3:0] a;
      logic [7:0] d;
      if (($urandom % 200) == 0) mode_single = ~mode_single;
      wr = ($urandom % 6) == 0;
      a = 4'($urandom % 9);
      d = 8'($urandom);
      if (a < 4'd6) d = d & 8'h03;
      tick(wr, a, d, 1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 3) == 0));
      check_all("R1 R2 R3 R4 R6 R9 random");
    end
    check_bases("R10 final");

    done = 1;
    summary();
    $finish;
  end
endmodule